// File: doc/BRIEF.md
# Prescaled Timer/Counter with Watchdog

This block is an 8-bit timer/counter paired with an independent watchdog counter. It sits beside a small processor core. The timer advances on the instruction-cycle clock, which is derived from the oscillator clock, or on edges of an external pin. An 8-bit prescaler can sit between the chosen source and the counter, or the counter can bypass it. When the counter wraps it raises a sticky overflow flag. The core may load a new count at any time, and each load also restarts the timer's prescaler.

The watchdog counts a free-running enable tick through its own 8-bit prescaler. Each time its counter wraps, it emits a one-cycle timeout pulse. Firmware holds the timeout off by issuing watchdog-clear strobes. A sleep strobe has the same clearing effect. While the chip sleeps, the internally clocked timer stops. The one exception is an analog conversion that has wake-up enabled, during which the timer keeps running.

All logic is synchronous to one clock. Reset is synchronous and active high.

Top module: `tmrw_core`

## Requirements
- R1: Reset clears the timer value to 0x00 and drives `tmr_ovf` and `wdt_timeout` low.
- R2: The instruction cycle lasts 2 clock cycles when `clk_div4` is 0 and 4 clock cycles when it is 1. With the internal source selected (`src_ext`=0) and the prescaler bypassed, the timer advances by one per instruction cycle.
- R3: When `psc_bypass` is 0, the timer advances once per 2^(`tmr_ratio`+1) source events, so field value 0 gives 2 and field value 7 gives 256. When `psc_bypass` is 1, it advances once per source event.
- R4: A `tmr_wr` strobe loads `tmr_wdata` into the timer on the next edge and clears the timer prescaler count, so a full prescaler period elapses before the next increment.
- R5: With `src_ext`=1, the timer counts edges of `pin_ext`: rising edges when `edge_fall`=0 and falling edges when `edge_fall`=1. The pin is sampled once per instruction cycle, so each level must be held for longer than one instruction cycle.
- R6: When `src_ext`=0, `sleep_mode`=1 and `adc_wake_run`=0, the timer holds its value. If `adc_wake_run` is 1, or if the external source is selected, counting continues during sleep.
- R7: When the timer wraps from 0xFF to 0x00, `tmr_ovf` goes high and stays high until an `ovf_clr` strobe. If a wrap and a clear fall in the same cycle, the set wins.
- R8: Each cycle in which `wdt_tick` is high counts into the watchdog prescaler, which divides by 2^(`wdt_ratio`+1). After 256 prescaled ticks, the watchdog counter wraps and `wdt_timeout` goes high for exactly one cycle.
- R9: A `wdt_clr` strobe or a `sleep_cmd` strobe clears both the watchdog counter and the watchdog prescaler, which delays the next timeout by a full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div4 | input | 1 | Instruction cycle is 4 clocks when 1, 2 clocks when 0 |
| src_ext | input | 1 | Timer counts the external pin when 1, the instruction cycle when 0 |
| edge_fall | input | 1 | Counts falling pin edges when 1, rising edges when 0 |
| pin_ext | input | 1 | External count pin (asynchronous) |
| psc_bypass | input | 1 | Timer skips its prescaler when 1 |
| tmr_ratio | input | 3 | Timer prescaler ratio, divide by 2^(value+1) |
| wdt_ratio | input | 3 | Watchdog prescaler ratio, divide by 2^(value+1) |
| tmr_wr | input | 1 | Timer load strobe |
| tmr_wdata | input | 8 | Value loaded by `tmr_wr` |
| ovf_clr | input | 1 | Clears the overflow flag |
| wdt_clr | input | 1 | Clears the watchdog and its prescaler |
| sleep_cmd | input | 1 | Sleep-entry strobe; clears the watchdog and its prescaler |
| sleep_mode | input | 1 | High while the chip sleeps |
| adc_wake_run | input | 1 | Conversion in progress with wake-up enabled |
| wdt_tick | input | 1 | Watchdog count enable |
| tmr_value | output | 8 | Current timer count |
| tmr_ovf | output | 1 | Sticky timer overflow flag |
| wdt_timeout | output | 1 | One-cycle watchdog timeout pulse |

## Verification
The count rate is swept over both instruction-cycle lengths and all nine prescaler settings (eight ratios plus bypass). Each setting is measured as the difference between two samples taken a whole number of periods apart, which makes the result independent of divider phase and exposes any wrong divide factor. External-pin trains that end on a high level give different counts for rising and falling mode, so an inverted edge select shows up. A load made halfway through a slow prescaler period separates a cleared prescaler from a stale one. On the watchdog side, windows just short of and just past the expected timeout, together with repeated clears and sleep strobes, tell apart the ratio, the single-cycle pulse width and each of the two clear paths.

// File: rtl/tmrw_pkg.sv
package tmrw_pkg;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_sel_e;

   typedef enum logic {
      SRC_CYCLE = 1'b0,
      SRC_PIN   = 1'b1
   } src_sel_e;

   // number of low count bits that must be all ones for a prescaled pulse
   function automatic int unsigned ratio_bits(input int unsigned sel);
      return sel + 1;
   endfunction

endpackage

// File: rtl/tmrw_cycgen.sv
module tmrw_cycgen #(
   parameter int unsigned FAST_DIV = 2,
   parameter int unsigned SLOW_DIV = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic slow,
   output logic cyc_en
);
   localparam int unsigned CW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
   localparam logic [CW-1:0] FAST_LIM = CW'(FAST_DIV - 1);
   localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_DIV - 1);

   generate
      if (FAST_DIV < 2) begin : g_bad_fast
         $error("tmrw_cycgen: FAST_DIV must be at least 2");
      end
      if (SLOW_DIV < FAST_DIV) begin : g_bad_slow
         $error("tmrw_cycgen: SLOW_DIV must not be below FAST_DIV");
      end
   endgenerate

   logic [CW-1:0] div_q;
   logic [CW-1:0] lim;

   assign lim    = slow ? SLOW_LIM : FAST_LIM;
   assign cyc_en = (div_q >= lim);

   always_ff @(posedge clk) begin
      if (rst) begin
         div_q <= '0;
      end else if (cyc_en) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   // R2: an instruction cycle never lasts a single clock
   p_cycle_gap_r2: assert property (@(posedge clk) disable iff (rst)
      cyc_en |=> !cyc_en);

endmodule

// File: rtl/tmrw_pinsync.sv
module tmrw_pinsync
   import tmrw_pkg::*;
#(
   parameter int unsigned STAGES = 2
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      en,
   input  logic      pin,
   input  edge_sel_e sel,
   output logic      edge_pls
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("tmrw_pinsync: STAGES must be at least 1");
      end
   endgenerate

   // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] the previous one
   logic [STAGES:0] sh_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (rst) begin
               sh_q <= '0;
            end else if (en) begin
               sh_q <= {sh_q[0], pin};
            end
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (rst) begin
               sh_q <= '0;
            end else if (en) begin
               sh_q <= {sh_q[STAGES-1:0], pin};
            end
         end
      end
   endgenerate

   logic lvl_now, lvl_old;
   assign lvl_now = sh_q[STAGES-1];
   assign lvl_old = sh_q[STAGES];

   always_comb begin
      edge_pls = 1'b0;
      if (en) begin
         if (sel == EDGE_FALL) edge_pls = lvl_old & ~lvl_now;
         else                  edge_pls = lvl_now & ~lvl_old;
      end
   end

   // R5: edges are only reported on instruction-cycle enables
   p_edge_on_cycle_r5: assert property (@(posedge clk) disable iff (rst)
      edge_pls |-> en);

endmodule

// File: rtl/tmrw_prescale.sv
module tmrw_prescale
   import tmrw_pkg::*;
#(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             tick,
   input  logic [SEL_W-1:0] sel,
   output logic             pls
);
   generate
      if ((1 << SEL_W) > CNT_W) begin : g_bad_width
         $error("tmrw_prescale: CNT_W too narrow for the ratio field");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] mask;

   generate
      for (genvar i = 0; i < CNT_W; i++) begin : g_mask
         assign mask[i] = (ratio_bits(int'(sel)) > i);
      end
   endgenerate

   assign pls = tick & ~clr & ((cnt_q & mask) == mask);

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R4/R9: a clear leaves the count at zero
   p_clr_zero_r4: assert property (@(posedge clk) disable iff (rst)
      clr |=> (cnt_q == '0));
   // R3: count moves only on ticks
   p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (!tick && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/tmrw_core.sv
module tmrw_core
   import tmrw_pkg::*;
#(
   parameter int unsigned TMR_W       = 8,
   parameter int unsigned WDT_W       = 8,
   parameter int unsigned PSC_W       = 8,
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FAST_DIV    = 2,
   parameter int unsigned SLOW_DIV    = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clk_div4,
   input  logic             src_ext,
   input  logic             edge_fall,
   input  logic             pin_ext,
   input  logic             psc_bypass,
   input  logic [SEL_W-1:0] tmr_ratio,
   input  logic [SEL_W-1:0] wdt_ratio,
   input  logic             tmr_wr,
   input  logic [TMR_W-1:0] tmr_wdata,
   input  logic             ovf_clr,
   input  logic             wdt_clr,
   input  logic             sleep_cmd,
   input  logic             sleep_mode,
   input  logic             adc_wake_run,
   input  logic             wdt_tick,
   output logic [TMR_W-1:0] tmr_value,
   output logic             tmr_ovf,
   output logic             wdt_timeout
);
   generate
      if (TMR_W < 2 || WDT_W < 2) begin : g_bad_cnt
         $error("tmrw_core: counter widths must be at least 2");
      end
   endgenerate

   // ---------------- instruction cycle ----------------
   logic cyc_en;

   tmrw_cycgen #(
      .FAST_DIV (FAST_DIV),
      .SLOW_DIV (SLOW_DIV)
   ) i_cycgen (
      .clk    (clk),
      .rst    (rst),
      .slow   (clk_div4),
      .cyc_en (cyc_en)
   );

   // ---------------- source selection ----------------
   logic      pin_edge;
   edge_sel_e esel;
   src_sel_e  ssel;
   logic      cyc_run;
   logic      src_tick;

   assign esel = edge_sel_e'(edge_fall);
   assign ssel = src_sel_e'(src_ext);

   tmrw_pinsync #(
      .STAGES (SYNC_STAGES)
   ) i_pinsync (
      .clk      (clk),
      .rst      (rst),
      .en       (cyc_en),
      .pin      (pin_ext),
      .sel      (esel),
      .edge_pls (pin_edge)
   );

   assign cyc_run  = cyc_en & (~sleep_mode | adc_wake_run);
   assign src_tick = (ssel == SRC_PIN) ? pin_edge : cyc_run;

   // ---------------- timer prescaler ----------------
   logic tpsc_pls;
   logic tmr_inc;

   tmrw_prescale #(
      .CNT_W (PSC_W),
      .SEL_W (SEL_W)
   ) i_tmr_psc (
      .clk  (clk),
      .rst  (rst),
      .clr  (tmr_wr),
      .tick (src_tick & ~psc_bypass),
      .sel  (tmr_ratio),
      .pls  (tpsc_pls)
   );

   assign tmr_inc = psc_bypass ? src_tick : tpsc_pls;

   // ---------------- timer counter and overflow ----------------
   logic [TMR_W-1:0] tmr_q;
   logic             ovf_q;
   logic             wrap;

   assign wrap = tmr_inc & ~tmr_wr & (tmr_q == '1);

   always_ff @(posedge clk) begin
      if (rst) begin
         tmr_q <= '0;
      end else if (tmr_wr) begin
         tmr_q <= tmr_wdata;
      end else if (tmr_inc) begin
         tmr_q <= tmr_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ovf_q <= 1'b0;
      end else if (wrap) begin
         ovf_q <= 1'b1;
      end else if (ovf_clr) begin
         ovf_q <= 1'b0;
      end
   end

   assign tmr_value = tmr_q;
   assign tmr_ovf   = ovf_q;

   // ---------------- watchdog ----------------
   logic             wclr;
   logic             wpsc_pls;
   logic [WDT_W-1:0] wdt_q;
   logic             tout_q;

   assign wclr = wdt_clr | sleep_cmd;

   tmrw_prescale #(
      .CNT_W (PSC_W),
      .SEL_W (SEL_W)
   ) i_wdt_psc (
      .clk  (clk),
      .rst  (rst),
      .clr  (wclr),
      .tick (wdt_tick),
      .sel  (wdt_ratio),
      .pls  (wpsc_pls)
   );

   always_ff @(posedge clk) begin
      if (rst || wclr) begin
         wdt_q  <= '0;
         tout_q <= 1'b0;
      end else begin
         tout_q <= wpsc_pls & (wdt_q == '1);
         if (wpsc_pls) wdt_q <= wdt_q + 1'b1;
      end
   end

   assign wdt_timeout = tout_q;

   // ---------------- assertions ----------------
   p_load_r4: assert property (@(posedge clk) disable iff (rst)
      tmr_wr |=> (tmr_value == $past(tmr_wdata)));
   p_step_r2: assert property (@(posedge clk) disable iff (rst)
      !tmr_wr |=> (tmr_value == $past(tmr_value) ||
                   tmr_value == TMR_W'($past(tmr_value) + 1'b1)));
   p_sleep_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!src_ext && sleep_mode && !adc_wake_run && !tmr_wr) |=> $stable(tmr_value));
   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      (tmr_ovf && !ovf_clr) |=> tmr_ovf);
   p_timeout_pulse_r8: assert property (@(posedge clk) disable iff (rst)
      wdt_timeout |=> !wdt_timeout);
   p_wdt_clear_r9: assert property (@(posedge clk) disable iff (rst)
      (wdt_clr || sleep_cmd) |=> (wdt_q == '0 && !wdt_timeout));

endmodule

// File: tb/test_tmrw_core.sv
module test_tmrw_core;

   logic       clk = 1'b0;
   logic       rst;
   logic       clk_div4, src_ext, edge_fall, pin_ext, psc_bypass;
   logic [2:0] tmr_ratio, wdt_ratio;
   logic       tmr_wr;
   logic [7:0] tmr_wdata;
   logic       ovf_clr, wdt_clr, sleep_cmd, sleep_mode, adc_wake_run, wdt_tick;
   logic [7:0] tmr_value;
   logic       tmr_ovf, wdt_timeout;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   tmrw_core i_tmrw_core (
      .clk          (clk),
      .rst          (rst),
      .clk_div4     (clk_div4),
      .src_ext      (src_ext),
      .edge_fall    (edge_fall),
      .pin_ext      (pin_ext),
      .psc_bypass   (psc_bypass),
      .tmr_ratio    (tmr_ratio),
      .wdt_ratio    (wdt_ratio),
      .tmr_wr       (tmr_wr),
      .tmr_wdata    (tmr_wdata),
      .ovf_clr      (ovf_clr),
      .wdt_clr      (wdt_clr),
      .sleep_cmd    (sleep_cmd),
      .sleep_mode   (sleep_mode),
      .adc_wake_run (adc_wake_run),
      .wdt_tick     (wdt_tick),
      .tmr_value    (tmr_value),
      .tmr_ovf      (tmr_ovf),
      .wdt_timeout  (wdt_timeout)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_tmr(input logic [7:0] v);
      tmr_wr    = 1'b1;
      tmr_wdata = v;
      cyc(1);
      tmr_wr    = 1'b0;
   endtask

   task automatic pulse_wclr(input bit use_sleep);
      if (use_sleep) sleep_cmd = 1'b1; else wdt_clr = 1'b1;
      cyc(1);
      sleep_cmd = 1'b0;
      wdt_clr   = 1'b0;
   endtask

   // counts timeout samples over n cycles
   task automatic count_tout(input int n, output int hits);
      hits = 0;
      for (int i = 0; i < n; i++) begin
         cyc(1);
         if (wdt_timeout) hits++;
      end
   endtask

   // pin train: 5 rising edges, 4 falling edges, ends high
   task automatic pin_train(input int hold);
      for (int i = 0; i < 5; i++) begin
         pin_ext = 1'b1;
         cyc(hold);
         if (i < 4) begin
            pin_ext = 1'b0;
            cyc(hold);
         end
      end
      cyc(30);
   endtask

   initial begin
      int v0, per, hits;
      rst = 1'b1;
      clk_div4 = 0; src_ext = 0; edge_fall = 0; pin_ext = 0; psc_bypass = 1;
      tmr_ratio = 0; wdt_ratio = 0; tmr_wr = 0; tmr_wdata = 0; ovf_clr = 0;
      wdt_clr = 0; sleep_cmd = 0; sleep_mode = 0; adc_wake_run = 0; wdt_tick = 0;
      cyc(4);
      // R1 reset state
      chk("R1 value", int'(tmr_value), 0);
      chk("R1 ovf", int'(tmr_ovf), 0);
      chk("R1 timeout", int'(wdt_timeout), 0);
      rst = 1'b0;

      // R2/R3 sweep of rate: cycle length x ratio (8 means bypass)
      for (int d = 0; d < 2; d++) begin
         for (int r = 0; r < 9; r++) begin
            clk_div4   = d[0];
            psc_bypass = (r == 8);
            tmr_ratio  = (r == 8) ? 3'd0 : 3'(r);
            per = (d == 1 ? 4 : 2) * ((r == 8) ? 1 : (2 << r));
            wr_tmr(8'h00);
            cyc(per + 4);
            v0 = int'(tmr_value);
            cyc(per * 3);
            chk($sformatf("R2/R3 rate div4=%0d ratio=%0d", d, r),
                int'(tmr_value), (v0 + 3) % 256);
         end
      end

      // R4 load clears prescaler: divide by 256 on 2-clock cycles
      clk_div4 = 0; psc_bypass = 0; tmr_ratio = 3'd7;
      wr_tmr(8'h10);
      cyc(300);
      wr_tmr(8'h40);
      chk("R4 loaded", int'(tmr_value), 8'h40);
      cyc(499);
      chk("R4 no early step", int'(tmr_value), 8'h40);
      cyc(30);
      chk("R4 step after full period", int'(tmr_value), 8'h41);

      // R7 overflow flag
      psc_bypass = 1;
      ovf_clr = 1; cyc(1); ovf_clr = 0;
      wr_tmr(8'hFD);
      chk("R7 no ovf before wrap", int'(tmr_ovf), 0);
      cyc(20);
      chk("R7 ovf set on wrap", int'(tmr_ovf), 1);
      cyc(100);
      chk("R7 ovf sticky", int'(tmr_ovf), 1);
      ovf_clr = 1; cyc(1); ovf_clr = 0;
      chk("R7 ovf cleared", int'(tmr_ovf), 0);

      // R6 sleep gating
      sleep_mode = 1; adc_wake_run = 0;
      wr_tmr(8'h20);
      cyc(100);
      chk("R6 held in sleep", int'(tmr_value), 8'h20);
      adc_wake_run = 1;
      cyc(4);
      v0 = int'(tmr_value);
      cyc(100);
      chk("R6 runs with conversion wake", int'(tmr_value), (v0 + 50) % 256);
      adc_wake_run = 0;
      src_ext = 1; edge_fall = 0;
      pin_ext = 0; cyc(20);
      wr_tmr(8'h00);
      pin_train(8);
      chk("R6 pin source runs in sleep", int'(tmr_value), 5);
      sleep_mode = 0;

      // R5 edge select, two cycle lengths
      for (int d = 0; d < 2; d++) begin
         for (int e = 0; e < 2; e++) begin
            clk_div4 = d[0]; edge_fall = e[0];
            pin_ext = 0; cyc(30);
            wr_tmr(8'h00);
            pin_train(d == 1 ? 12 : 8);
            chk($sformatf("R5 edges div4=%0d fall=%0d", d, e),
                int'(tmr_value), (e == 1) ? 4 : 5);
         end
      end
      src_ext = 0; pin_ext = 0;

      // R8 watchdog period, ratio 2 -> 512 cycles
      wdt_tick = 1; wdt_ratio = 3'd0;
      pulse_wclr(0);
      count_tout(500, hits);
      chk("R8 no early timeout ratio2", hits, 0);
      count_tout(30, hits);
      chk("R8 single timeout pulse ratio2", hits, 1);
      // ratio 4 -> 1024 cycles
      wdt_ratio = 3'd1;
      pulse_wclr(0);
      count_tout(1000, hits);
      chk("R8 no early timeout ratio4", hits, 0);
      count_tout(40, hits);
      chk("R8 single timeout pulse ratio4", hits, 1);
      // no tick, no timeout
      wdt_tick = 0; wdt_ratio = 3'd0;
      count_tout(1200, hits);
      chk("R8 idle without tick", hits, 0);
      wdt_tick = 1;

      // R9 clears by both strobes keep timeout away
      pulse_wclr(0);
      count_tout(400, hits);
      chk("R9 before sleep strobe", hits, 0);
      pulse_wclr(1);
      count_tout(400, hits);
      chk("R9 sleep strobe clears", hits, 0);
      pulse_wclr(0);
      count_tout(400, hits);
      chk("R9 clear strobe clears", hits, 0);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule